// File: doc/BRIEF.md
# Clock Generator Configuration Store with Split Reset Domains

This block holds the configuration of a small clock tree. It has a set of clock generators. Each generator has a source select, a divider value and an enable. It also has a set of clock channels. Each channel picks one generator and has an enable and a one-way lock bit. A few oscillator and system-divider settings sit beside them. Software loads all of it through one write port. The values go straight out on ports to the clock logic that uses them. This block does no dividing and no switching of clocks.

Two reset inputs set what is restored:

- **Power reset** returns everything to a fixed start-up state.
- **User reset** is selective. It restores the generators, the fast oscillator settings and every channel that is not protected. Three kinds of channel are protected and keep their settings:
  - a locked channel;
  - the watchdog channel, while the always-on watchdog bit is high;
  - the channel named as the real-time-clock channel, if it is enabled.

  The low-frequency crystal setting is left alone by a user reset.

Top module: `clkcfg_top`

## Requirements
- R1: After power reset, generator 0 is enabled with source code 0 (8 MHz internal oscillator) and divider 0, meaning undivided. Generator 2 is enabled with source code 1 (32 kHz ultra-low-power oscillator) and divider 0. Every other generator has enable 0, source 0 and divider 0.
- R2: After power reset, every channel has enable 0, lock 0 and generator select 0. The one exception is the watchdog channel (parameter WDT_CH, default 3), which has enable 1 and generator select 2.
- R3: After power reset, the fast oscillator enable is 1 and its prescale code is 3 (divide by 8). The low-frequency crystal enable is 0. The CPU and bus divider codes are 0 (undivided).
- R4: A write takes effect on the clock edge where wr_en is high. The address decodes as follows:
  - Address 0 is the oscillator word: bit 0 is the fast oscillator enable, bits 2:1 are the prescale code, and bit 4 is the crystal enable.
  - Address 1 is the system divider word: bits 3:0 are the CPU code and bits 7:4 are the bus code.
  - Addresses 2 to 5 are generators 0 to 3: bits 2:0 are the source, bits 15:8 are the divider, and bit 16 is the enable.
  - Addresses 6 to 13 are channels 0 to 7: bits 1:0 are the generator select, bit 8 is the enable, and bit 9 is the lock.
- R5: A user reset returns every generator to its R1 value.
- R6: A user reset returns every unprotected channel to its R2 value.
- R7: A channel whose lock bit is set keeps its generator select, its enable and its lock through a user reset.
- R8: While wdt_always_on is 1, the watchdog channel keeps its settings through a user reset. While it is 0, that channel returns to its R2 value.
- R9: The channel whose index is on rtc_ch_idx keeps its settings through a user reset if its enable is 1 at that edge. If its enable is 0, it returns to its R2 value.
- R10: A user reset returns the fast oscillator and the CPU and bus dividers to their R3 values. It leaves the crystal enable unchanged.
- R11: Writes to a locked channel have no effect. Only a power reset clears the lock.
- R12: When power reset and user reset are high in the same cycle, power reset wins. All state, including locked channels and the crystal enable, takes its start-up value.
- R13: A write in a cycle where either reset is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power reset, synchronous, active high |
| urst | input | 1 | User reset, synchronous, active high |
| wdt_always_on | input | 1 | Always-on watchdog configuration bit |
| rtc_ch_idx | input | 3 | Index of the real-time-clock channel |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| gen_src | output | 12 | Source select of each generator, 3 bits per generator |
| gen_div | output | 32 | Divider of each generator, 8 bits per generator |
| gen_en | output | 4 | Enable of each generator |
| ch_gen | output | 16 | Generator select of each channel, 2 bits per channel |
| ch_en | output | 8 | Enable of each channel |
| ch_lock | output | 8 | Lock of each channel |
| hs_osc_en | output | 1 | Fast oscillator enable |
| hs_osc_presc | output | 2 | Fast oscillator prescale code |
| lf_xosc_en | output | 1 | Low-frequency crystal enable |
| cpu_div | output | 4 | CPU divider code |
| bus_div | output | 4 | Bus divider code |

## Verification
The bench targets the protection rules.

- **Locked channel.** It is rewritten and then hit with a user reset. A design that accepted the write, or cleared the lock on a user reset, shows changed channel fields.
- **Watchdog and real-time-clock channels.** Each is reset once with its protection condition true and once with it false. This catches a design that ignores the always-on bit, or that keeps a disabled real-time-clock channel.
- **Crystal enable.** It is set before a user reset and must still read 1 after it. It must read 0 after a power reset.
- **Reset collisions.** Power and user reset are driven in the same cycle, and a write is driven during a reset. These expose a priority order that lets a user reset or a write win.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [2:0] {
        SRC_OSC8M   = 3'd0,
        SRC_ULP32K  = 3'd1,
        SRC_XOSC32K = 3'd2,
        SRC_XOSC    = 3'd3,
        SRC_PLL     = 3'd4,
        SRC_DFLL    = 3'd5
    } src_e;

    localparam int SRC_W     = 3;
    localparam int GEN_MAIN  = 0;
    localparam int GEN_LP    = 2;

    // field positions inside the write word
    localparam int F_GEN_DIV = 8;
    localparam int F_GEN_EN  = 16;
    localparam int F_CH_EN   = 8;
    localparam int F_CH_LOCK = 9;
    localparam int F_HS_EN   = 0;
    localparam int F_HS_PRE  = 1;
    localparam int F_LF_EN   = 4;
    localparam int F_CPU_DIV = 0;
    localparam int F_BUS_DIV = 4;

    localparam logic [1:0] HS_PRESC_RST = 2'd3;

    function automatic logic gen_rst_en(input int g);
        return (g == GEN_MAIN) || (g == GEN_LP);
    endfunction

    function automatic src_e gen_rst_src(input int g);
        return (g == GEN_LP) ? SRC_ULP32K : SRC_OSC8M;
    endfunction

endpackage

// File: rtl/clkcfg_gen_bank.sv
module clkcfg_gen_bank
    import clkcfg_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int DIV_W   = 8,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     any_rst,
    input  logic [NUM_GEN-1:0]       wr_hit,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_GEN*SRC_W-1:0] gen_src,
    output logic [NUM_GEN*DIV_W-1:0] gen_div,
    output logic [NUM_GEN-1:0]       gen_en
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        src_e              src_q;
        logic [DIV_W-1:0]  div_q;
        logic              en_q;

        always_ff @(posedge clk) begin
            if (any_rst) begin
                src_q <= gen_rst_src(g);
                div_q <= '0;
                en_q  <= gen_rst_en(g);
            end else if (wr_hit[g]) begin
                src_q <= src_e'(wr_data[SRC_W-1:0]);
                div_q <= wr_data[F_GEN_DIV +: DIV_W];
                en_q  <= wr_data[F_GEN_EN];
            end
        end

        assign gen_src[g*SRC_W +: SRC_W] = src_q;
        assign gen_div[g*DIV_W +: DIV_W] = div_q;
        assign gen_en[g]                 = en_q;
    end
endmodule

// File: rtl/clkcfg_chan_bank.sv
module clkcfg_chan_bank
    import clkcfg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int GSEL_W = 2,
    parameter int WDT_CH = 3,
    parameter int DATA_W = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     por,
    input  logic                     urst,
    input  logic                     wdt_always_on,
    input  logic [CH_W-1:0]          rtc_ch_idx,
    input  logic [NUM_CH-1:0]        wr_hit,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*GSEL_W-1:0] ch_gen,
    output logic [NUM_CH-1:0]        ch_en,
    output logic [NUM_CH-1:0]        ch_lock
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam bit IS_WDT = (c == WDT_CH);
        localparam logic [GSEL_W-1:0] GSEL_RST = IS_WDT ? GSEL_W'(GEN_LP) : '0;

        logic [GSEL_W-1:0] gsel_q;
        logic              en_q;
        logic              lock_q;
        logic              keep;

        always_comb begin
            keep = lock_q
                 | (IS_WDT && wdt_always_on)
                 | ((rtc_ch_idx == CH_W'(c)) && en_q);
        end

        always_ff @(posedge clk) begin
            if (por) begin
                gsel_q <= GSEL_RST;
                en_q   <= IS_WDT;
                lock_q <= 1'b0;
            end else if (urst) begin
                if (!keep) begin
                    gsel_q <= GSEL_RST;
                    en_q   <= IS_WDT;
                    lock_q <= 1'b0;
                end
            end else if (wr_hit[c] && !lock_q) begin
                gsel_q <= wr_data[GSEL_W-1:0];
                en_q   <= wr_data[F_CH_EN];
                lock_q <= wr_data[F_CH_LOCK];
            end
        end

        assign ch_gen[c*GSEL_W +: GSEL_W] = gsel_q;
        assign ch_en[c]                   = en_q;
        assign ch_lock[c]                 = lock_q;
    end
endmodule

// File: rtl/clkcfg_src_regs.sv
module clkcfg_src_regs
    import clkcfg_pkg::*;
#(
    parameter int SYSDIV_W = 4,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                por,
    input  logic                urst,
    input  logic                wr_osc,
    input  logic                wr_sys,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                hs_osc_en,
    output logic [1:0]          hs_osc_presc,
    output logic                lf_xosc_en,
    output logic [SYSDIV_W-1:0] cpu_div,
    output logic [SYSDIV_W-1:0] bus_div
);
    // fast oscillator and system dividers: every reset
    always_ff @(posedge clk) begin
        if (por || urst) begin
            hs_osc_en    <= 1'b1;
            hs_osc_presc <= HS_PRESC_RST;
            cpu_div      <= '0;
            bus_div      <= '0;
        end else begin
            if (wr_osc) begin
                hs_osc_en    <= wr_data[F_HS_EN];
                hs_osc_presc <= wr_data[F_HS_PRE +: 2];
            end
            if (wr_sys) begin
                cpu_div <= wr_data[F_CPU_DIV +: SYSDIV_W];
                bus_div <= wr_data[F_BUS_DIV +: SYSDIV_W];
            end
        end
    end

    // low-frequency crystal: power reset only, frozen during user reset
    always_ff @(posedge clk) begin
        if (por) begin
            lf_xosc_en <= 1'b0;
        end else if (wr_osc && !urst) begin
            lf_xosc_en <= wr_data[F_LF_EN];
        end
    end
endmodule

// File: rtl/clkcfg_top.sv
module clkcfg_top
    import clkcfg_pkg::*;
#(
    parameter int NUM_GEN  = 4,
    parameter int NUM_CH   = 8,
    parameter int DIV_W    = 8,
    parameter int WDT_CH   = 3,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int SYSDIV_W = 4,
    localparam int GSEL_W  = $clog2(NUM_GEN),
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                      clk,
    input  logic                      por,
    input  logic                      urst,
    input  logic                      wdt_always_on,
    input  logic [CH_W-1:0]           rtc_ch_idx,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_GEN*SRC_W-1:0]  gen_src,
    output logic [NUM_GEN*DIV_W-1:0]  gen_div,
    output logic [NUM_GEN-1:0]        gen_en,
    output logic [NUM_CH*GSEL_W-1:0]  ch_gen,
    output logic [NUM_CH-1:0]         ch_en,
    output logic [NUM_CH-1:0]         ch_lock,
    output logic                      hs_osc_en,
    output logic [1:0]                hs_osc_presc,
    output logic                      lf_xosc_en,
    output logic [SYSDIV_W-1:0]       cpu_div,
    output logic [SYSDIV_W-1:0]       bus_div
);
    localparam int A_OSC   = 0;
    localparam int A_SYS   = 1;
    localparam int A_GEN0  = 2;
    localparam int A_CH0   = A_GEN0 + NUM_GEN;

    logic                 any_rst;
    logic                 wr_ok;
    logic                 wr_osc, wr_sys;
    logic [NUM_GEN-1:0]   gen_hit;
    logic [NUM_CH-1:0]    ch_hit;

    assign any_rst = por | urst;
    assign wr_ok   = wr_en & ~any_rst;
    assign wr_osc  = wr_ok && (wr_addr == ADDR_W'(A_OSC));
    assign wr_sys  = wr_ok && (wr_addr == ADDR_W'(A_SYS));

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gdec
        assign gen_hit[g] = wr_ok && (wr_addr == ADDR_W'(A_GEN0 + g));
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cdec
        assign ch_hit[c] = wr_ok && (wr_addr == ADDR_W'(A_CH0 + c));
    end

    clkcfg_gen_bank #(.NUM_GEN(NUM_GEN), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_gen (
        .clk     (clk),
        .any_rst (any_rst),
        .wr_hit  (gen_hit),
        .wr_data (wr_data),
        .gen_src (gen_src),
        .gen_div (gen_div),
        .gen_en  (gen_en)
    );

    clkcfg_chan_bank #(.NUM_CH(NUM_CH), .GSEL_W(GSEL_W), .WDT_CH(WDT_CH),
                       .DATA_W(DATA_W)) u_ch (
        .clk           (clk),
        .por           (por),
        .urst          (urst),
        .wdt_always_on (wdt_always_on),
        .rtc_ch_idx    (rtc_ch_idx),
        .wr_hit        (ch_hit),
        .wr_data       (wr_data),
        .ch_gen        (ch_gen),
        .ch_en         (ch_en),
        .ch_lock       (ch_lock)
    );

    clkcfg_src_regs #(.SYSDIV_W(SYSDIV_W), .DATA_W(DATA_W)) u_src (
        .clk          (clk),
        .por          (por),
        .urst         (urst),
        .wr_osc       (wr_osc),
        .wr_sys       (wr_sys),
        .wr_data      (wr_data),
        .hs_osc_en    (hs_osc_en),
        .hs_osc_presc (hs_osc_presc),
        .lf_xosc_en   (lf_xosc_en),
        .cpu_div      (cpu_div),
        .bus_div      (bus_div)
    );
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk
    import clkcfg_pkg::*;
#(
    parameter int NUM_GEN  = 4,
    parameter int NUM_CH   = 8,
    parameter int DIV_W    = 8,
    parameter int WDT_CH   = 3,
    parameter int SYSDIV_W = 4,
    localparam int GSEL_W  = $clog2(NUM_GEN)
) (
    input logic                     clk,
    input logic                     por,
    input logic                     urst,
    input logic                     wdt_always_on,
    input logic [NUM_GEN*SRC_W-1:0] gen_src,
    input logic [NUM_GEN*DIV_W-1:0] gen_div,
    input logic [NUM_GEN-1:0]       gen_en,
    input logic [NUM_CH*GSEL_W-1:0] ch_gen,
    input logic [NUM_CH-1:0]        ch_en,
    input logic [NUM_CH-1:0]        ch_lock,
    input logic                     hs_osc_en,
    input logic [1:0]               hs_osc_presc,
    input logic                     lf_xosc_en,
    input logic [SYSDIV_W-1:0]      cpu_div,
    input logic [SYSDIV_W-1:0]      bus_div
);
    AST_MAIN_GEN_AFTER_RESET: assert property (@(posedge clk) disable iff (por)
        $past(por || urst) |-> gen_en[GEN_MAIN] && gen_src[GEN_MAIN*SRC_W +: SRC_W] == SRC_OSC8M
                               && gen_div[GEN_MAIN*DIV_W +: DIV_W] == '0); // R1

    AST_FAST_OSC_AFTER_RESET: assert property (@(posedge clk) disable iff (por)
        $past(por || urst) |-> hs_osc_en && hs_osc_presc == HS_PRESC_RST
                               && cpu_div == '0 && bus_div == '0); // R10

    AST_XTAL_SURVIVES_USER_RESET: assert property (@(posedge clk) disable iff (por)
        $past(urst) && !$past(por) |-> $stable(lf_xosc_en)); // R10

    AST_WDT_ALWAYS_ON_HOLDS: assert property (@(posedge clk) disable iff (por)
        $past(urst) && !$past(por) && $past(wdt_always_on)
        |-> $stable(ch_en[WDT_CH]) && $stable(ch_gen[WDT_CH*GSEL_W +: GSEL_W])); // R8

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lock
        AST_LOCKED_CHANNEL_FROZEN: assert property (@(posedge clk) disable iff (por)
            $past(ch_lock[c]) && !$past(por)
            |-> ch_lock[c] && $stable(ch_en[c]) && $stable(ch_gen[c*GSEL_W +: GSEL_W])); // R11
    end
endmodule

bind clkcfg_top clkcfg_chk #(
    .NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH), .DIV_W(DIV_W),
    .WDT_CH(WDT_CH), .SYSDIV_W(SYSDIV_W)
) u_chk (
    .clk(clk), .por(por), .urst(urst), .wdt_always_on(wdt_always_on),
    .gen_src(gen_src), .gen_div(gen_div), .gen_en(gen_en),
    .ch_gen(ch_gen), .ch_en(ch_en), .ch_lock(ch_lock),
    .hs_osc_en(hs_osc_en), .hs_osc_presc(hs_osc_presc), .lf_xosc_en(lf_xosc_en),
    .cpu_div(cpu_div), .bus_div(bus_div)
);

// File: tb/sim_clkcfg_top.sv
module sim_clkcfg_top;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        urst = 1'b0;
    logic        wdt_always_on = 1'b0;
    logic [2:0]  rtc_ch_idx = 3'd6;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] gen_src;
    logic [31:0] gen_div;
    logic [3:0]  gen_en;
    logic [15:0] ch_gen;
    logic [7:0]  ch_en, ch_lock;
    logic        hs_osc_en, lf_xosc_en;
    logic [1:0]  hs_osc_presc;
    logic [3:0]  cpu_div, bus_div;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clkcfg_top u0 (
        .clk(clk), .por(por), .urst(urst), .wdt_always_on(wdt_always_on),
        .rtc_ch_idx(rtc_ch_idx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gen_src(gen_src), .gen_div(gen_div), .gen_en(gen_en),
        .ch_gen(ch_gen), .ch_en(ch_en), .ch_lock(ch_lock),
        .hs_osc_en(hs_osc_en), .hs_osc_presc(hs_osc_presc), .lf_xosc_en(lf_xosc_en),
        .cpu_div(cpu_div), .bus_div(bus_div)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // packed generator view {en, div, src}
    function automatic logic [31:0] gen_word(input int g);
        return {20'd0, gen_en[g], gen_div[g*8 +: 8], gen_src[g*3 +: 3]};
    endfunction
    // packed channel view {lock, en, gsel}
    function automatic logic [31:0] ch_word(input int c);
        return {28'd0, ch_lock[c], ch_en[c], ch_gen[c*2 +: 2]};
    endfunction
    function automatic logic [31:0] gen_exp(input logic en, input logic [7:0] dv, input logic [2:0] s);
        return {20'd0, en, dv, s};
    endfunction
    function automatic logic [31:0] ch_exp(input logic lk, input logic en, input logic [1:0] gs);
        return {28'd0, lk, en, gs};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask
    task automatic pulse(input logic p, input logic u);
        @(negedge clk); por = p; urst = u;
        @(negedge clk); por = 1'b0; urst = 1'b0;
    endtask

    task automatic t_por_state;
        pulse(1'b1, 1'b0);
        chk("R1 gen0", gen_word(0), gen_exp(1'b1, 8'd0, 3'd0));
        chk("R1 gen1", gen_word(1), 32'd0);
        chk("R1 gen2", gen_word(2), gen_exp(1'b1, 8'd0, 3'd1));
        chk("R1 gen3", gen_word(3), 32'd0);
        for (int c = 0; c < 8; c++)
            chk("R2 chan", ch_word(c), (c == 3) ? ch_exp(1'b0, 1'b1, 2'd2) : 32'd0);
        chk("R3 osc", {hs_osc_en, hs_osc_presc, lf_xosc_en}, {1'b1, 2'd3, 1'b0});
        chk("R3 div", {cpu_div, bus_div}, 8'h00);
    endtask

    task automatic t_writes_then_user_reset;
        pulse(1'b1, 1'b0);
        wdt_always_on = 1'b0;
        wr(4'd3, 32'h0001_0705);              // gen1: en, div 7, src 5
        wr(4'd2, 32'h0001_0003);              // gen0: src 3
        wr(4'd11, 32'h0000_0101);             // ch5: en, gsel 1
        wr(4'd9, 32'h0000_0001);              // ch3 (watchdog): disabled, gsel 1
        wr(4'd0, 32'h0000_0012);              // hs off, presc 1, lf on
        wr(4'd1, 32'h0000_0032);              // cpu 2, bus 3
        chk("R4 gen1", gen_word(1), gen_exp(1'b1, 8'd7, 3'd5));
        chk("R4 ch5", ch_word(5), ch_exp(1'b0, 1'b1, 2'd1));
        chk("R4 osc", {hs_osc_en, hs_osc_presc, lf_xosc_en}, {1'b0, 2'd1, 1'b1});
        chk("R4 sys", {cpu_div, bus_div}, {4'd2, 4'd3});
        pulse(1'b0, 1'b1);
        chk("R5 gen0", gen_word(0), gen_exp(1'b1, 8'd0, 3'd0));
        chk("R5 gen1", gen_word(1), 32'd0);
        chk("R6 ch5", ch_word(5), 32'd0);
        chk("R8 wdt no always-on", ch_word(3), ch_exp(1'b0, 1'b1, 2'd2));
        chk("R10 osc", {hs_osc_en, hs_osc_presc, lf_xosc_en}, {1'b1, 2'd3, 1'b1});
        chk("R10 sys", {cpu_div, bus_div}, 8'h00);
    endtask

    task automatic t_lock;
        pulse(1'b1, 1'b0);
        wr(4'd7, 32'h0000_0303);              // ch1: lock, en, gsel 3
        wr(4'd7, 32'h0000_0000);
        chk("R11 locked write ignored", ch_word(1), ch_exp(1'b1, 1'b1, 2'd3));
        pulse(1'b0, 1'b1);
        chk("R7 locked kept", ch_word(1), ch_exp(1'b1, 1'b1, 2'd3));
        pulse(1'b1, 1'b0);
        chk("R11 por clears lock", ch_word(1), 32'd0);
        wr(4'd7, 32'h0000_0102);
        chk("R11 write after por", ch_word(1), ch_exp(1'b0, 1'b1, 2'd2));
    endtask

    task automatic t_wdt_always_on;
        pulse(1'b1, 1'b0);
        wr(4'd9, 32'h0000_0101);
        wdt_always_on = 1'b1;
        pulse(1'b0, 1'b1);
        chk("R8 wdt kept", ch_word(3), ch_exp(1'b0, 1'b1, 2'd1));
        wdt_always_on = 1'b0;
        pulse(1'b0, 1'b1);
        chk("R8 wdt restored", ch_word(3), ch_exp(1'b0, 1'b1, 2'd2));
    endtask

    task automatic t_rtc;
        pulse(1'b1, 1'b0);
        rtc_ch_idx = 3'd6;
        wr(4'd12, 32'h0000_0102);             // ch6: en, gsel 2
        wr(4'd13, 32'h0000_0101);             // ch7: en, gsel 1
        pulse(1'b0, 1'b1);
        chk("R9 rtc enabled kept", ch_word(6), ch_exp(1'b0, 1'b1, 2'd2));
        chk("R6 non-rtc cleared", ch_word(7), 32'd0);
        wr(4'd12, 32'h0000_0003);             // ch6 disabled, gsel 3
        pulse(1'b0, 1'b1);
        chk("R9 rtc disabled cleared", ch_word(6), 32'd0);
    endtask

    task automatic t_priority;
        pulse(1'b1, 1'b0);
        wr(4'd6, 32'h0000_0301);              // ch0 locked
        wr(4'd0, 32'h0000_0017);              // lf on
        pulse(1'b1, 1'b1);
        chk("R12 lock cleared", ch_word(0), 32'd0);
        chk("R12 xtal cleared", {31'd0, lf_xosc_en}, 32'd0);
    endtask

    task automatic t_write_in_reset;
        pulse(1'b1, 1'b0);
        @(negedge clk); urst = 1'b1; wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'h0001_0204;
        @(negedge clk); urst = 1'b0; wr_en = 1'b0;
        chk("R13 gen3 write dropped", gen_word(3), 32'd0);
        @(negedge clk); por = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h0000_0010;
        @(negedge clk); por = 1'b0; wr_en = 1'b0;
        chk("R13 osc write dropped", {31'd0, lf_xosc_en}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por = 1'b0;
        t_por_state();
        t_writes_then_user_reset();
        t_lock();
        t_wdt_always_on();
        t_rtc();
        t_priority();
        t_write_in_reset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule